// File: doc/BRIEF.md
# Skip-Sequence Modulo-Six Counter

This block is a free-running three-bit counter. On every rising clock edge it moves one step around a fixed loop of six codes, 0, 1, 2, 4, 5, 6, and then returns to 0. The codes 3 and 7 are left out of the loop. Each of the three state bits is a JK-style storage cell. Fixed excitation logic, taken from the present state alone, drives the J and K inputs of each cell. The count is presented as bits A (most significant), B and C.

Neither 3 nor 7 can occur in normal counting. If the state still lands on one of them, through a glitch or a direct load, the excitation logic brings it back into the loop on the very next edge. The counter is therefore self-starting. A synchronous reset clears the count to 0. A load port is provided for test use only: it writes an arbitrary three-bit code into the cells, so the recovery paths can be exercised from the pins.

Top module: `skip6_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count becomes 000 at that edge. Reset takes priority over `load_en`.
- R2: With `rst` and `load_en` low, the count steps 000→001→010→100→101→110→000 and repeats every six clocks. The count is the binary value {A,B,C}, with A at bit 2.
- R3: Without a load or reset on the previous edge, the count never shows 011 or 111.
- R4: From code 011, one normal edge moves the count to 100.
- R5: From code 111, one normal edge moves the count to 000.
- R6: Each state bit obeys the JK rule at a normal edge. J=0, K=0 holds the bit. J=0, K=1 clears it. J=1, K=0 sets it. J=1, K=1 inverts it.
- R7: With `rst` low and `load_en` high at an edge, the count takes the value of `load_code` at that edge.
- R8: The excitation equations are J_A=B, K_A=B, J_B=C, K_B=1, J_C=not B, K_C=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Test-only: write `load_code` into the state |
| load_code | input | 3 | Test-only: code to be written |
| count | output | 3 | Present count {A,B,C} |

## Verification
The hardest condition to reach from the pins is the pair of unused codes. Normal counting never produces 3 or 7, so their recovery paths would otherwise never run. The bench uses the test-only load port to place 011 and then 111 in the state. It then releases the load and watches the single recovery edge that follows. After that edge it checks that the counter continues around the regular loop.

// File: rtl/skip6_pkg.sv
package skip6_pkg;
  localparam int CNT_W   = 3;
  localparam int SEQ_LEN = 6;
  localparam int BIT_A   = CNT_W - 1;
  localparam int BIT_B   = CNT_W - 2;
  localparam int BIT_C   = 0;

  typedef logic [CNT_W-1:0] code_t;

  // JK storage rule for one bit
  function automatic logic jk_rule(input logic q, input logic j, input logic k);
    logic r;
    unique case ({j, k})
      2'b00: r = q;
      2'b01: r = 1'b0;
      2'b10: r = 1'b1;
      default: r = ~q;
    endcase
    return r;
  endfunction

  // Intended successor, written as a table of the loop plus recovery codes
  function automatic code_t seq_next(input code_t c);
    code_t r;
    unique case (c)
      3'd0: r = 3'd1;
      3'd1: r = 3'd2;
      3'd2: r = 3'd4;
      3'd3: r = 3'd4;
      3'd4: r = 3'd5;
      3'd5: r = 3'd6;
      3'd6: r = 3'd0;
      default: r = 3'd0;
    endcase
    return r;
  endfunction

  function automatic logic is_unused(input code_t c);
    return (c == 3'd3) || (c == 3'd7);
  endfunction
endpackage

// File: rtl/skip6_excite.sv
module skip6_excite
  import skip6_pkg::*;
(
  input  logic [CNT_W-1:0] state,
  output logic [CNT_W-1:0] j_vec,
  output logic [CNT_W-1:0] k_vec
);
  logic a_q, b_q, c_q;

  assign a_q = state[BIT_A];
  assign b_q = state[BIT_B];
  assign c_q = state[BIT_C];

  // R8: minimized excitation, unused codes treated as don't-care
  always_comb begin
    j_vec        = '0;
    k_vec        = '0;
    j_vec[BIT_A] = b_q;
    k_vec[BIT_A] = b_q;
    j_vec[BIT_B] = c_q;
    k_vec[BIT_B] = 1'b1;
    j_vec[BIT_C] = ~b_q;
    k_vec[BIT_C] = 1'b1;
  end

  always_comb begin
    AST_KB_KC_HIGH: assert (k_vec[BIT_B] && k_vec[BIT_C]); // R8
    AST_JA_EQ_KA: assert (j_vec[BIT_A] == k_vec[BIT_A] || $isunknown(a_q)); // R8
  end
endmodule

// File: rtl/skip6_jk_cell.sv
module skip6_jk_cell
  import skip6_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ld_en,
  input  logic ld_val,
  input  logic j,
  input  logic k,
  output logic q
);
  logic step_en;
  logic q_next;

  assign step_en = !rst && !ld_en;
  assign q_next  = jk_rule(q, j, k);

  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (ld_en) q <= ld_val;
    else            q <= q_next;
  end

  AST_JK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (step_en && !j && !k) |=> (q == $past(q))); // R6
  AST_JK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (step_en && !j && k) |=> !q); // R6
  AST_JK_SET: assert property (@(posedge clk) disable iff (rst)
    (step_en && j && !k) |=> q); // R6
  AST_JK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (step_en && j && k) |=> (q != $past(q))); // R6
endmodule

// File: rtl/skip6_counter.sv
module skip6_counter
  import skip6_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_code,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] j_vec;
  logic [CNT_W-1:0] k_vec;
  logic [CNT_W-1:0] state_q;
  logic             normal_step;
  logic             on_unused;

  assign normal_step = !rst && !load_en;
  assign on_unused   = is_unused(state_q);

  skip6_excite u_excite (
    .state (state_q),
    .j_vec (j_vec),
    .k_vec (k_vec)
  );

  for (genvar gi = 0; gi < CNT_W; gi++) begin : g_bit
    skip6_jk_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .ld_en  (load_en),
      .ld_val (load_code[gi]),
      .j      (j_vec[gi]),
      .k      (k_vec[gi]),
      .q      (state_q[gi])
    );
  end

  assign count = state_q;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (count == '0)); // R1
  AST_LOOP_STEP: assert property (@(posedge clk) disable iff (rst)
    normal_step |=> (count == seq_next($past(count)))); // R2
  AST_NO_UNUSED: assert property (@(posedge clk) disable iff (rst)
    normal_step |=> !on_unused); // R3
  AST_RECOVER_3: assert property (@(posedge clk) disable iff (rst)
    (normal_step && count == 3'd3) |=> (count == 3'd4)); // R4
  AST_RECOVER_7: assert property (@(posedge clk) disable iff (rst)
    (normal_step && count == 3'd7) |=> (count == 3'd0)); // R5
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (count == $past(load_code))); // R7
endmodule

// File: tb/skip6_counter_bench.sv
module skip6_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_en = 1'b0;
  logic [2:0] load_code = 3'd0;
  logic [2:0] count;
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  skip6_counter u_skip6_counter (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .load_code (load_code),
    .count     (count)
  );

  function automatic logic [2:0] expect_next(input logic [2:0] c);
    logic [2:0] loop_tbl [6] = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5, 3'd6};
    for (int i = 0; i < 6; i++)
      if (loop_tbl[i] == c) return loop_tbl[(i + 1) % 6];
    return (c == 3'd3) ? 3'd4 : 3'd0;
  endfunction

  task automatic check(input string req, input logic [2:0] exp);
    n_chk++;
    if (count !== exp) begin
      n_fail++;
      $display("FAIL %s: count=%0d expected=%0d", req, count, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; load_en = 1'b1; load_code = 3'd5;
    tick(); tick();
    check("R1", 3'd0);
    load_en = 1'b0; rst = 1'b0;
    check("R1", 3'd0);
  endtask

  task automatic t_full_loop();
    logic [2:0] exp;
    exp = count;
    for (int n = 0; n < 13; n++) begin
      exp = expect_next(exp);
      tick();
      check("R2", exp);
      n_chk++;
      if (count == 3'd3 || count == 3'd7) begin
        n_fail++;
        $display("FAIL R3: count=%0d expected=not 3 or 7", count);
      end
    end
  endtask

  task automatic t_load(input logic [2:0] code);
    load_en = 1'b1; load_code = code;
    tick();
    load_en = 1'b0;
    check("R7", code);
  endtask

  task automatic t_unused3();
    t_load(3'd3);
    tick();
    check("R4", 3'd4);
    tick();
    check("R8", 3'd5);
  endtask

  task automatic t_unused7();
    t_load(3'd7);
    tick();
    check("R5", 3'd0);
    tick();
    check("R6", 3'd1);
  endtask

  task automatic t_reset_midrun();
    t_load(3'd5);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R1", 3'd0);
    tick();
    check("R6", 3'd1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_full_loop();
    t_unused3();
    t_unused7();
    t_load(3'd6);
    tick();
    check("R2", 3'd0);
    t_reset_midrun();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run=hung expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule